// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the input port of a stereo DAC datapath. An external source drives the bit clock, the word-select clock and the serial data line. The port never generates either clock. It rebuilds one left sample and one right sample per word-select period and delivers the pair as two parallel words in the system clock domain, with a one-cycle strobe.

Three framing styles are decoded at run time from a 3-bit format code: I2S, MSB-justified, and LSB-justified at 16, 18 or 20 bits. Each word is placed left-aligned in a DATA_W-bit output. For the LSB-justified styles the port has to locate the first valid bit by counting back from the word-select edge, and the number of bits depends on the chosen length. A new format code is applied only at a left-channel boundary, and the frame that was in flight across the change is dropped.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `left_out` and `right_out` are zero and `sample_valid` is low. No strobe is produced while the bit clock is idle.
- R2: With format code 000 (I2S), a word's MSB is the bit sampled one bit clock after the word-select transition. Later bits follow MSB first.
- R3: With format code 001 (MSB-justified), a word's MSB is the bit sampled on the same bit-clock rising edge that first sees the new word-select level.
- R4: With codes 010, 011 and 100 (LSB-justified at 16, 18 and 20 bits), the LSB is the last bit sampled before the word-select transition. The word is the N bits ending there, and earlier bits of the slot are ignored.
- R5: The codes 101, 110 and 111 decode exactly as code 000.
- R6: Words sent while word-select is low appear on `left_out`, and words sent while it is high appear on `right_out`.
- R7: A word shorter than DATA_W bits is left-aligned in its output, and the unused LSBs are zero. This applies in every style, including slots of only 16 bit clocks.
- R8: In I2S and MSB-justified framing, bits after the first DATA_W bits of a word do not affect the output.
- R9: Each complete left/right pair produces exactly one `sample_valid` pulse of one system clock cycle.
- R10: A change of `fmt_sel` takes effect only at the next left-channel word boundary. The frame that starts at that boundary is not emitted. A change that is undone before a left boundary has no effect.
- R11: `left_out` and `right_out` change only in the cycle in which `sample_valid` is high, and they hold their values in between.
- R12: Serial data and word-select are sampled on the rising edge of the bit clock. The finished pair reaches the system clock domain through a toggle passed through SYNC_STAGES flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256, 384 or 512 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released separately in each clock domain |
| bclk | input | 1 | Bit clock from the external source |
| ws | input | 1 | Word select: low is left, high is right |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Framing code: 000 I2S, 001 MSB-justified, 010/011/100 LSB-justified 16/18/20, others I2S |
| left_out | output | DATA_W (20) | Left sample, left-aligned |
| right_out | output | DATA_W (20) | Right sample, left-aligned |
| sample_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench builds the block with DATA_W = 20 and SYNC_STAGES = 2, so every LSB-justified length fits the output exactly and the 20-bit cap on long words can be reached with 24-bit test words. It runs every format code, including one reserved code, with 32-bit-clock slots, and it runs I2S and MSB-justified with 16-bit-clock slots so that zero-padding and the one-bit I2S carry into the next slot are exercised. The expected words are derived arithmetically from the transmitted values. The bench also changes the format briefly and restores it in the middle of a frame, and it counts strobes against the number of frames that should survive each format change.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'd0,
    FMT_MSBJ  = 3'd1,
    FMT_LSB16 = 3'd2,
    FMT_LSB18 = 3'd3,
    FMT_LSB20 = 3'd4
  } fmt_e;

  localparam int unsigned LSB_LEN_SHORT = 16;
  localparam int unsigned LSB_LEN_MID   = 18;
  localparam int unsigned LSB_LEN_LONG  = 20;

  // Reserved codes map to I2S framing.
  function automatic fmt_e fmt_decode(input logic [2:0] code);
    fmt_e f;
    case (code)
      3'd1:    f = FMT_MSBJ;
      3'd2:    f = FMT_LSB16;
      3'd3:    f = FMT_LSB18;
      3'd4:    f = FMT_LSB20;
      default: f = FMT_I2S;
    endcase
    return f;
  endfunction

  // Word length counted back from the word-select edge; zero for MSB-first styles.
  function automatic int unsigned lsb_len(input fmt_e f);
    int unsigned n;
    case (f)
      FMT_LSB16: n = LSB_LEN_SHORT;
      FMT_LSB18: n = LSB_LEN_MID;
      FMT_LSB20: n = LSB_LEN_LONG;
      default:   n = 0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/sar_bit_front.sv
module sar_bit_front
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W = 20
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              ws,
  input  logic              sd,
  input  fmt_e              fmt_act,
  output logic              start,
  output logic              new_chan,
  output logic [DATA_W-1:0] word
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic              ws_q, ws_d;
  logic              edge_q, edge_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] lsr_q, lsr_d;
  logic              acc_en;
  logic              edge_now;
  logic [CNT_W-1:0]  len;
  logic [CNT_W-1:0]  pad;
  logic [DATA_W-1:0] mask;

  // Word boundary: I2S starts one bit clock after the word-select change.
  always_comb begin
    edge_now = ws ^ ws_q;
    if (fmt_act == FMT_I2S) begin
      start    = edge_q;
      new_chan = ws_q;
    end else begin
      start    = edge_now;
      new_chan = ws;
    end
  end

  // Decode of the word that ends at this boundary.
  always_comb begin
    len  = CNT_W'(lsb_len(fmt_act));
    mask = (DATA_W'(1) << len) - DATA_W'(1);
    pad  = CNT_W'(DATA_W) - cnt_q;
    if (len != '0) begin
      word = (lsr_q & mask) << (CNT_W'(DATA_W) - len);
    end else begin
      word = acc_q << pad;
    end
  end

  // Next state.
  always_comb begin
    ws_d   = ws;
    edge_d = edge_now;
    lsr_d  = {lsr_q[DATA_W-2:0], sd};
    acc_en = start || (cnt_q != CNT_W'(DATA_W));
    if (start) begin
      acc_d = {{(DATA_W-1){1'b0}}, sd};
      cnt_d = CNT_W'(1);
    end else begin
      acc_d = {acc_q[DATA_W-2:0], sd};
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q   <= 1'b0;
      edge_q <= 1'b0;
      lsr_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else begin
      ws_q   <= ws_d;
      edge_q <= edge_d;
      lsr_q  <= lsr_d;
      if (acc_en) begin
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/sar_frame_asm.sv
module sar_frame_asm
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W = 20
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              new_chan,
  input  logic [DATA_W-1:0] word,
  input  logic [2:0]        fmt_sel,
  output fmt_e              fmt_act,
  output logic              left_start,
  output logic [DATA_W-1:0] pair_l,
  output logic [DATA_W-1:0] pair_r,
  output logic              pair_tgl
);

  fmt_e              fmt_new, fmt_d;
  logic              frame_ok_q, frame_ok_d;
  logic              got_left_q, got_left_d;
  logic [DATA_W-1:0] hold_l_q, hold_l_d;
  logic [DATA_W-1:0] pair_l_d, pair_r_d;
  logic              tgl_d;
  logic              right_start;
  logic              emit;

  always_comb begin
    fmt_new     = fmt_decode(fmt_sel);
    left_start  = start & ~new_chan;
    right_start = start & new_chan;
    emit        = left_start & frame_ok_q & got_left_q;
  end

  // Next state; a left word is trusted only if a right boundary preceded it.
  always_comb begin
    fmt_d      = fmt_new;
    frame_ok_d = (fmt_new == fmt_act) && got_left_q;
    got_left_d = new_chan;
    hold_l_d   = word;
    pair_l_d   = hold_l_q;
    pair_r_d   = word;
    tgl_d      = ~pair_tgl;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_act    <= FMT_I2S;
      frame_ok_q <= 1'b0;
      got_left_q <= 1'b0;
      hold_l_q   <= '0;
      pair_l     <= '0;
      pair_r     <= '0;
      pair_tgl   <= 1'b0;
    end else begin
      if (left_start) begin
        fmt_act    <= fmt_d;
        frame_ok_q <= frame_ok_d;
      end
      if (start) begin
        got_left_q <= got_left_d;
      end
      if (right_start) begin
        hold_l_q <= hold_l_d;
      end
      if (emit) begin
        pair_l   <= pair_l_d;
        pair_r   <= pair_r_d;
        pair_tgl <= tgl_d;
      end
    end
  end

endmodule

// File: rtl/sar_cdc_out.sv
module sar_cdc_out #(
  parameter int unsigned DATA_W      = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pair_l,
  input  logic [DATA_W-1:0] pair_r,
  input  logic              pair_tgl,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              sample_valid
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   seen_q, seen_d;
  logic                   fire;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pair_tgl};
    seen_d = sync_q[SYNC_STAGES-1];
    fire   = sync_q[SYNC_STAGES-1] ^ seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q       <= '0;
      seen_q       <= 1'b0;
      sample_valid <= 1'b0;
      left_out     <= '0;
      right_out    <= '0;
    end else begin
      sync_q       <= sync_d;
      seen_q       <= seen_d;
      sample_valid <= fire;
      if (fire) begin
        left_out  <= pair_l;
        right_out <= pair_r;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int unsigned DATA_W      = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              ws,
  input  logic              sdata,
  input  logic [2:0]        fmt_sel,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              sample_valid
);

  logic              rst_sys_n;
  logic              rst_bclk_n;
  logic              start;
  logic              new_chan;
  logic [DATA_W-1:0] word;
  fmt_e              fmt_act;
  logic              left_start;
  logic [DATA_W-1:0] pair_l;
  logic [DATA_W-1:0] pair_r;
  logic              pair_tgl;

  sar_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sys_n)
  );

  sar_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_bclk (
    .clk     (bclk),
    .arst_n  (rst_n),
    .rst_n_o (rst_bclk_n)
  );

  sar_bit_front #(.DATA_W(DATA_W)) u_front (
    .bclk     (bclk),
    .rst_n    (rst_bclk_n),
    .ws       (ws),
    .sd       (sdata),
    .fmt_act  (fmt_act),
    .start    (start),
    .new_chan (new_chan),
    .word     (word)
  );

  sar_frame_asm #(.DATA_W(DATA_W)) u_frame (
    .bclk       (bclk),
    .rst_n      (rst_bclk_n),
    .start      (start),
    .new_chan   (new_chan),
    .word       (word),
    .fmt_sel    (fmt_sel),
    .fmt_act    (fmt_act),
    .left_start (left_start),
    .pair_l     (pair_l),
    .pair_r     (pair_r),
    .pair_tgl   (pair_tgl)
  );

  sar_cdc_out #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk          (clk),
    .rst_n        (rst_sys_n),
    .pair_l       (pair_l),
    .pair_r       (pair_r),
    .pair_tgl     (pair_tgl),
    .left_out     (left_out),
    .right_out    (right_out),
    .sample_valid (sample_valid)
  );

endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int unsigned DATA_W = 20
) (
  input logic              clk,
  input logic              rst_sys_n,
  input logic              bclk,
  input logic              rst_bclk_n,
  input logic              sample_valid,
  input logic [DATA_W-1:0] left_out,
  input logic [DATA_W-1:0] right_out,
  input logic              left_start,
  input logic [2:0]        fmt_act,
  input logic              pair_tgl
);

  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    sample_valid |=> !sample_valid);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_sys_n)
    !sample_valid |-> ($stable(left_out) && $stable(right_out)));

  // R10
  fmt_hold_chk: assert property (@(posedge bclk) disable iff (!rst_bclk_n)
    !left_start |=> $stable(fmt_act));

  // R9
  pair_tgl_chk: assert property (@(posedge bclk) disable iff (!rst_bclk_n)
    !left_start |=> $stable(pair_tgl));

endmodule

bind serial_audio_rx sar_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_sys_n    (rst_sys_n),
  .bclk         (bclk),
  .rst_bclk_n   (rst_bclk_n),
  .sample_valid (sample_valid),
  .left_out     (left_out),
  .right_out    (right_out),
  .left_start   (left_start),
  .fmt_act      (fmt_act),
  .pair_tgl     (pair_tgl)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  localparam int NPH = 8;
  localparam int NFR = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        ws = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic [19:0] left_out;
  logic [19:0] right_out;
  logic        sample_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [19:0] got_l[$];
  logic [19:0] got_r[$];
  logic [19:0] exp_l[$];
  logic [19:0] exp_r[$];
  string       exp_tag[$];

  int          run_len  = 0;
  int          max_run  = 0;
  int          hold_bad = 0;
  logic [19:0] prev_l   = '0;
  logic [19:0] prev_r   = '0;
  logic        prev_bit = 1'b0;

  int    ph_code  [NPH] = '{0, 1, 2, 3, 4, 7, 1, 0};
  int    ph_slots [NPH] = '{32, 32, 32, 32, 32, 32, 16, 16};
  string ph_req   [NPH] = '{"R2 R6 R12", "R3 R8", "R4", "R4", "R4", "R5", "R7 R3", "R7 R2"};

  serial_audio_rx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk         (bclk),
    .ws           (ws),
    .sdata        (sdata),
    .fmt_sel      (fmt_sel),
    .left_out     (left_out),
    .right_out    (right_out),
    .sample_valid (sample_valid)
  );

  // 50 MHz system clock: 20 time units per period.
  always #10 clk = ~clk;

  // Monitor, away from the active edge.
  always @(negedge clk) begin
    if (sample_valid) begin
      got_l.push_back(left_out);
      got_r.push_back(right_out);
      run_len = run_len + 1;
      if (run_len > max_run) max_run = run_len;
    end else begin
      run_len = 0;
      if (left_out != prev_l || right_out != prev_r) hold_bad = hold_bad + 1;
    end
    prev_l = left_out;
    prev_r = right_out;
  end

  task automatic check(input string req, input string what,
                       input logic [19:0] act, input logic [19:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Bit in slot s of one channel, MSB-first framing per format code.
  function automatic logic bit_at(input int code, input int slots, input int s,
                                  input logic [23:0] v, input logic prev);
    int len;
    int wl;
    len = (code == 2) ? 16 : (code == 3) ? 18 : (code == 4) ? 20 : 0;
    wl  = (slots == 16) ? 16 : 24;
    if (len != 0) return (s >= slots - len) ? v[slots-1-s] : 1'b1;
    if (code == 1) return (s < wl) ? v[wl-1-s] : 1'b1;
    if (s == 0) return prev;
    return (s <= wl) ? v[wl-s] : 1'b1;
  endfunction

  function automatic logic [19:0] expect_word(input int code, input int slots,
                                              input logic [23:0] v);
    case (code)
      2: return {v[15:0], 4'b0};
      3: return {v[17:0], 2'b0};
      4: return v[19:0];
      default: return (slots == 16) ? {v[15:0], 4'b0} : v[23:4];
    endcase
  endfunction

  task automatic send_frame(input int code, input int slots, input logic [23:0] lv,
                            input logic [23:0] rv, input bit glitch);
    fmt_sel = code[2:0];
    for (int ch = 0; ch < 2; ch++) begin
      logic [23:0] v;
      v = (ch == 0) ? lv : rv;
      for (int s = 0; s < slots; s++) begin
        if (glitch && ch == 1 && s == 4) fmt_sel = 3'd1;
        if (glitch && ch == 1 && s == 9) fmt_sel = code[2:0];
        ws    = ch[0];
        sdata = bit_at(code, slots, s, v, prev_bit);
        #80 bclk = 1'b1;
        #80 bclk = 1'b0;
      end
      prev_bit = v[0];
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL R9 watchdog: actual %0d pairs expected %0d", got_l.size(), exp_l.size());
      finish_run();
    end
  end

  initial begin
    #3;
    #100 rst_n = 1'b1;
    #200;
    // R1: reset state
    check("R1", "left after reset", left_out, 20'h0);
    check("R1", "right after reset", right_out, 20'h0);
    check("R1", "valid after reset", {19'b0, sample_valid}, 20'h0);
    // Idle bit clocks release the bit-clock reset.
    for (int i = 0; i < 8; i++) begin
      ws = 1'b0; sdata = 1'b1;
      #80 bclk = 1'b1;
      #80 bclk = 1'b0;
    end
    #200;
    check("R1", "pulses while idle", 20'(got_l.size()), 20'h0);

    for (int p = 0; p < NPH; p++) begin
      for (int f = 0; f < NFR; f++) begin
        logic [23:0] lv;
        logic [23:0] rv;
        bit          gl;
        if (f == 1) begin
          lv = 24'hFFFFFF;
          rv = 24'h000000;
        end else begin
          lv = 24'(p * 32'h13579 + f * 32'h2468B + 32'h0F0F1);
          rv = 24'(lv * 5 + 24'h000777);
        end
        gl = (p == 3 && f == 3);
        send_frame(ph_code[p], ph_slots[p], lv, rv, gl);
        // R10: the first frame after a format change is dropped.
        if (f >= 1) begin
          exp_l.push_back(expect_word(ph_code[p], ph_slots[p], lv));
          exp_r.push_back(expect_word(ph_code[p], ph_slots[p], rv));
          exp_tag.push_back(gl ? "R10" : ph_req[p]);
        end
      end
    end
    // Trailing frame closes the last emitted pair.
    send_frame(ph_code[NPH-1], ph_slots[NPH-1], 24'h123456, 24'h654321, 1'b0);
    #1000;

    // R9, R10: one pulse per surviving frame
    check("R9 R10", "pair count", 20'(got_l.size()), 20'(exp_l.size()));
    for (int i = 0; i < exp_l.size(); i++) begin
      if (i < got_l.size()) begin
        check(exp_tag[i], $sformatf("left pair %0d", i), got_l[i], exp_l[i]);
        check(exp_tag[i], $sformatf("right pair %0d", i), got_r[i], exp_r[i]);
      end
    end
    // R9: strobe width
    check("R9", "max strobe width", 20'(max_run), 20'd1);
    // R11: outputs held between strobes
    check("R11", "output changes without strobe", 20'(hold_bad), 20'd0);
    finish_run();
  end

endmodule